// File: doc/BRIEF.md
# Pixel Color Match Event Decoder

The block sits in a parallel RGB video path of 24-bit pixel words with horizontal sync, vertical sync and active-video strobes. On each rising clock edge it checks the incoming pixel against a fixed table of color patterns. All compares run at the same time. Each pattern belongs to one of a set of event outputs. An event output rises when any of its patterns matched, and it is registered, so it shows one clock after the pixel.

The pixel and its three strobes go through one register stage. On the output side they therefore line up with the event flags that the same pixel produced. Downstream logic can use a flag to act on exactly the pixel that raised it. One chosen event can also replace the delayed pixel with a constant color inside the block.

The table is computed at elaboration from the pattern index, so no list is written out. With the defaults there are 60 patterns and 20 events, and each event owns three patterns.

Top module: `pix_match_event_top`

## Requirements
- R1: While rst_ni is low, evt_o, pix_o, hs_o, vs_o and act_o are all zero.
- R2: Pattern k (k = 0..59) has the color pix[23:16] = (37k+5) mod 256, pix[15:8] = (11k+130) mod 256, pix[7:0] = 3k+17. All 60 colors are distinct.
- R3: Pattern k belongs to event k mod 20. If the pixel sampled at an edge has act_i high and equals a pattern, the bit of that pattern's event in evt_o is high after that edge.
- R4: At most one bit of evt_o is high at any time, because a pixel can equal only one pattern.
- R5: A pixel sampled with act_i low drives evt_o to all zeros after that edge, whatever its color.
- R6: hs_o, vs_o and act_o equal hs_i, vs_i and act_i from one clock earlier.
- R7: While evt_o[3] is low, pix_o equals pix_i from one clock earlier.
- R8: While evt_o[3] is high, pix_o equals 24'h00FF00 and hs_o, vs_o and act_o still follow R6.
- R9: An active pixel that equals no pattern drives evt_o to all zeros after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 24 | Incoming pixel, R in [23:16], G in [15:8], B in [7:0] |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in |
| act_i | input | 1 | Active-video strobe in |
| pix_o | output | 24 | Delayed pixel, replaced when the selected event is high |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |
| act_o | output | 1 | Delayed active-video strobe |
| evt_o | output | 20 | Registered event flags |

## Verification
A wrong table entry or a wrong pattern-to-event mapping shows up as a missing or misplaced event bit. It appears on the clock after that color is presented, so all 60 colors are driven one per cycle. A missing active-video qualifier raises events during blanking on the next clock. A video register out of step shows pix_o or a strobe that disagrees with the previous input on every cycle. A replacement on the wrong event puts the fixed color on the wrong pixels in the same cycle as the flag.

// File: rtl/pix_match_pkg.sv
package pix_match_pkg;

  localparam int unsigned PIX_W = 24;

  typedef struct packed {
    logic [PIX_W-1:0] pix;
    logic             hs;
    logic             vs;
    logic             act;
  } video_t;

  // colors are distinct while 3k+17 < 256
  function automatic logic [PIX_W-1:0] pat_color(input int k);
    logic [7:0] r, g, b;
    r = 8'(k * 37 + 5);
    g = 8'(k * 11 + 130);
    b = 8'(k * 3 + 17);
    return {r, g, b};
  endfunction

endpackage

// File: rtl/pm_compare.sv
module pm_compare
  import pix_match_pkg::*;
#(
  parameter int unsigned NUM_PAT = 60
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PIX_W-1:0]   pix_i,
  input  logic               act_i,
  output logic [NUM_PAT-1:0] hit_o
);

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_pat
    localparam logic [PIX_W-1:0] PatColor = pat_color(k);
    assign hit_o[k] = act_i && (pix_i == PatColor);
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o)); // R4

endmodule

// File: rtl/pm_event_reduce.sv
module pm_event_reduce #(
  parameter int unsigned NUM_PAT = 60,
  parameter int unsigned NUM_EVT = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PAT-1:0] hit_i,
  input  logic               act_i,
  output logic [NUM_EVT-1:0] evt_o
);

  logic [NUM_EVT-1:0] evt_d;

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    logic [NUM_PAT-1:0] own_mask;
    always_comb begin
      own_mask = '0;
      for (int k = e; k < NUM_PAT; k += NUM_EVT) own_mask[k] = 1'b1;
    end
    assign evt_d[e] = |(hit_i & own_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= evt_d;
  end

  AST_HIT_RAISES_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> (|evt_o)); // R3
  AST_IDLE_NO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (evt_o == '0)); // R5
  AST_EVT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_o)); // R4

endmodule

// File: rtl/pm_video_delay.sv
module pm_video_delay
  import pix_match_pkg::*;
#(
  parameter int unsigned     NUM_EVT    = 20,
  parameter bit              REPL_EN    = 1'b1,
  parameter int unsigned     REPL_EVT   = 3,
  parameter logic [PIX_W-1:0] REPL_COLOR = 24'h00FF00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  video_t             vid_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output video_t             vid_o
);

  video_t vid_q;
  logic   repl_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vid_q <= '0;
    else         vid_q <= vid_i;
  end

  if (REPL_EN) begin : g_repl
    assign repl_sel = evt_i[REPL_EVT];
  end else begin : g_norepl
    assign repl_sel = 1'b0;
  end

  always_comb begin
    vid_o = vid_q;
    if (repl_sel) vid_o.pix = REPL_COLOR;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vid_o.hs == $past(vid_i.hs) && vid_o.vs == $past(vid_i.vs)
              && vid_o.act == $past(vid_i.act))); // R6
  AST_PIX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i[REPL_EVT] |-> (vid_o.pix == $past(vid_i.pix))); // R7

endmodule

// File: rtl/pix_match_event_top.sv
module pix_match_event_top
  import pix_match_pkg::*;
#(
  parameter int unsigned      NUM_PAT    = 60,
  parameter int unsigned      NUM_EVT    = 20,
  parameter bit               REPL_EN    = 1'b1,
  parameter int unsigned      REPL_EVT   = 3,
  parameter logic [PIX_W-1:0] REPL_COLOR = 24'h00FF00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PIX_W-1:0]   pix_i,
  input  logic               hs_i,
  input  logic               vs_i,
  input  logic               act_i,
  output logic [PIX_W-1:0]   pix_o,
  output logic               hs_o,
  output logic               vs_o,
  output logic               act_o,
  output logic [NUM_EVT-1:0] evt_o
);

  logic [NUM_PAT-1:0] hit;
  video_t             vid_in, vid_out;

  assign vid_in = '{pix: pix_i, hs: hs_i, vs: vs_i, act: act_i};

  pm_compare #(.NUM_PAT(NUM_PAT)) i_compare (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pix_i (pix_i),
    .act_i (act_i),
    .hit_o (hit)
  );

  pm_event_reduce #(.NUM_PAT(NUM_PAT), .NUM_EVT(NUM_EVT)) i_reduce (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .act_i (act_i),
    .evt_o (evt_o)
  );

  pm_video_delay #(
    .NUM_EVT   (NUM_EVT),
    .REPL_EN   (REPL_EN),
    .REPL_EVT  (REPL_EVT),
    .REPL_COLOR(REPL_COLOR)
  ) i_video (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vid_i (vid_in),
    .evt_i (evt_o),
    .vid_o (vid_out)
  );

  assign pix_o = vid_out.pix;
  assign hs_o  = vid_out.hs;
  assign vs_o  = vid_out.vs;
  assign act_o = vid_out.act;

endmodule

// File: tb/test_pix_match_event_top.sv
module test_pix_match_event_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pix = '0;
  logic        hs = 1'b0, vs = 1'b0, act = 1'b0;
  logic [23:0] pix_o;
  logic        hs_o, vs_o, act_o;
  logic [19:0] evt_o;

  int n_chk = 0;
  int n_err = 0;
  logic [23:0] lfsr = 24'h5A3C91;

  always #4 clk = ~clk;

  pix_match_event_top i_pix_match_event_top (
    .clk_i(clk), .rst_ni(rst_n),
    .pix_i(pix), .hs_i(hs), .vs_i(vs), .act_i(act),
    .pix_o(pix_o), .hs_o(hs_o), .vs_o(vs_o), .act_o(act_o),
    .evt_o(evt_o)
  );

  function automatic logic [23:0] color_of(input int k);
    logic [7:0] r, g, b;
    r = 8'(k * 37 + 5);
    g = 8'(k * 11 + 130);
    b = 8'(k * 3 + 17);
    return {r, g, b};
  endfunction

  function automatic logic [19:0] exp_evt(input logic [23:0] p, input logic a);
    logic [19:0] e = '0;
    for (int k = 0; k < 60; k++)
      if (a && p == color_of(k)) e[k % 20] = 1'b1;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act_v,
                     input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // drive one vector at a falling edge, check outputs at the next falling edge
  task automatic step(input logic [23:0] p, input logic h, input logic v,
                      input logic a, input string req);
    logic [19:0] e;
    logic [23:0] ep;
    pix = p; hs = h; vs = v; act = a;
    @(negedge clk);
    e  = exp_evt(p, a);
    ep = e[3] ? 24'h00FF00 : p;
    chk(evt_o == e, {req, " evt"}, 32'(evt_o), 32'(e));
    chk(pix_o == ep, "R7/R8 pix", 32'(pix_o), 32'(ep));
    chk({hs_o, vs_o, act_o} == {h, v, a}, "R6 sync", 32'({hs_o, vs_o, act_o}),
        32'({h, v, a}));
  endtask

  task automatic test_reset();
    pix = 24'hFFFFFF; hs = 1'b1; vs = 1'b1; act = 1'b1;
    repeat (3) @(negedge clk);
    chk(evt_o == '0, "R1 evt", 32'(evt_o), 0);
    chk(pix_o == '0, "R1 pix", 32'(pix_o), 0);
    chk({hs_o, vs_o, act_o} == 3'b000, "R1 sync", 32'({hs_o, vs_o, act_o}), 0);
    pix = '0; hs = 1'b0; vs = 1'b0; act = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_all_patterns();
    for (int k = 0; k < 60; k++) begin
      step(color_of(k), 1'b0, 1'b0, 1'b1, "R2 R3");
      chk(evt_o == (20'd1 << (k % 20)), "R3 map", 32'(evt_o), 32'(20'd1 << (k % 20)));
    end
  endtask

  task automatic test_inactive();
    for (int k = 0; k < 60; k += 7) begin
      step(color_of(k), 1'b1, k[0], 1'b0, "R5");
      chk(evt_o == '0, "R5 blank", 32'(evt_o), 0);
    end
  endtask

  task automatic test_no_match();
    step(24'h000000, 1'b0, 1'b0, 1'b1, "R9");
    step(24'hFFFFFF, 1'b1, 1'b0, 1'b1, "R9");
    step(color_of(5) ^ 24'h000001, 1'b0, 1'b1, 1'b1, "R9");
    chk(evt_o == '0, "R9 near miss", 32'(evt_o), 0);
  endtask

  task automatic test_replace();
    step(color_of(3), 1'b1, 1'b0, 1'b1, "R8");
    chk(pix_o == 24'h00FF00, "R8 repl", 32'(pix_o), 32'h00FF00);
    step(color_of(23), 1'b0, 1'b1, 1'b1, "R8");
    step(color_of(4), 1'b1, 1'b1, 1'b1, "R7");
    chk(pix_o == color_of(4), "R7 pass", 32'(pix_o), 32'(color_of(4)));
    step(color_of(43), 1'b0, 1'b0, 1'b0, "R5");
    chk(pix_o == color_of(43), "R5 R7 blank pass", 32'(pix_o), 32'(color_of(43)));
  endtask

  task automatic test_random();
    for (int i = 0; i < 400; i++) begin
      logic [23:0] p;
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      p = (i % 3 == 0) ? color_of(int'(lfsr[5:0]) % 60) : lfsr;
      step(p, lfsr[7], lfsr[9], (i % 11) != 0, "R3 R4 R9 mix");
      chk($countones(evt_o) <= 1, "R4 onehot", 32'(evt_o), 0);
    end
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_all_patterns();
        test_inactive();
        test_no_match();
        test_replace();
        test_random();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule